// File: doc/BRIEF.md
# Binary-Tree Magnitude Comparator

This block compares two unsigned operands of a parameterized width and raises exactly one of three flags: greater, equal or less. It is purely combinational. The result comes from a tree of small cells instead of a subtractor or a flat chain. Each tree level cuts both operands into 2-bit slices, starting from the least significant end. A cell reduces each pair of slices to one bit per operand. The reduced bits still record which operand is larger, so each level roughly halves the width. The tree stops when one bit per operand remains, and a small decoder turns that bit pair into the three flags.

A cell emits the pair (1,0) when the slice of operand A is larger, (0,1) when the slice of B is larger, and (0,0) when the slices are equal. The output bit of each cell stays in the same relative position, so higher slices remain more significant at the next level. When a level has an odd width, both operands gain a leading zero bit. The tree therefore has ceil(log2 WIDTH) levels, and a width of one needs no level at all.

Top module: `mag_tree_cmp`

## Requirements
- R1: `isGreater` is 1 exactly when `opA` is greater than `opB`, both read as unsigned binary numbers.
- R2: `isEqual` is 1 exactly when `opA` and `opB` carry identical bit patterns.
- R3: `isLess` is 1 exactly when `opA` is less than `opB`, both read as unsigned binary numbers.
- R4: For any pair of inputs, exactly one of `isGreater`, `isEqual` and `isLess` is 1.
- R5: The outputs depend only on the present inputs. They follow any change of inputs with no clock and keep no state from earlier inputs.
- R6: When the operands differ, the highest differing bit position alone decides the result. Bits below that position have no effect on the outputs.
- R7: Widths that are not a power of two give correct results, including when the operands differ only in the most significant bit. Examples are 3 and 33, where a level has an odd width and is padded with a zero.
- R8: With `WIDTH` = 1 the block has no tree level. It maps 1 versus 0 to greater, 0 versus 1 to less, and equal bits to equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| isGreater | output | 1 | opA greater than opB |
| isEqual | output | 1 | opA equal to opB |
| isLess | output | 1 | opA less than opB |

## Verification
The hardest situation to reach from the ports is a single differing bit that must travel up through every level of the tree. This matters most when that bit enters a padded slice at an odd-width level, where a wrong pad or a swapped slice shows up only for a few bit positions. The bench walks a single differing bit across every position at width 33. It keeps the bits below that position opposite to the decided direction and the bits above it equal. It also runs exhaustive sweeps at widths 1, 2, 3 and 8, plus pseudo-random pairs from a shift register at width 33.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  // Width of the operands after `level` halving steps (ceiling at each step).
  function automatic int widthAt(input int startWidth, input int level);
    int w;
    w = startWidth;
    for (int k = 0; k < level; k++) begin
      w = (w + 1) / 2;
    end
    return w;
  endfunction

  // Number of halving steps needed to reach a single bit per operand.
  function automatic int treeDepth(input int startWidth);
    int d;
    d = 0;
    while (widthAt(startWidth, d) > 1) begin
      d++;
    end
    return d;
  endfunction

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmpFlags_t;

endpackage

// File: rtl/mag_pair_cell.sv
module mag_pair_cell (
  input  logic [1:0] sliceA,
  input  logic [1:0] sliceB,
  output logic       bitA,
  output logic       bitB
);
  logic hiAWins;
  logic hiBWins;
  logic hiTie;
  logic loAWins;
  logic loBWins;

  always_comb begin
    hiAWins = sliceA[1] & ~sliceB[1];
    hiBWins = ~sliceA[1] & sliceB[1];
    hiTie   = ~(sliceA[1] ^ sliceB[1]);
    loAWins = sliceA[0] & ~sliceB[0];
    loBWins = ~sliceA[0] & sliceB[0];
    bitA    = hiAWins | (hiTie & loAWins);
    bitB    = hiBWins | (hiTie & loBWins);
  end
endmodule

// File: rtl/mag_tree_level.sv
module mag_tree_level #(
  parameter int IN_W = 4
) (
  input  logic [IN_W-1:0]          inA,
  input  logic [IN_W-1:0]          inB,
  output logic [(IN_W+1)/2-1:0]    outA,
  output logic [(IN_W+1)/2-1:0]    outB
);
  localparam int OUT_W = (IN_W + 1) / 2;
  localparam int PAD_W = 2 * OUT_W;

  logic [PAD_W-1:0] padA;
  logic [PAD_W-1:0] padB;

  // Odd widths gain a zero in the top position on both operands.
  assign padA = PAD_W'(inA);
  assign padB = PAD_W'(inB);

  for (genvar i = 0; i < OUT_W; i++) begin : g_cell
    mag_pair_cell uCell (
      .sliceA (padA[2*i+1:2*i]),
      .sliceB (padB[2*i+1:2*i]),
      .bitA   (outA[i]),
      .bitB   (outB[i])
    );
  end
endmodule

// File: rtl/mag_tree_decode.sv
module mag_tree_decode
  import magcmp_pkg::*;
(
  input  logic      finA,
  input  logic      finB,
  output cmpFlags_t flags
);
  always_comb begin
    flags.gt = finA & ~finB;
    flags.lt = ~finA & finB;
    flags.eq = ~(finA ^ finB);
  end
endmodule

// File: rtl/mag_tree_cmp.sv
module mag_tree_cmp
  import magcmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             isGreater,
  output logic             isEqual,
  output logic             isLess
);
  localparam int LEVELS = treeDepth(WIDTH);

  logic      finA;
  logic      finB;
  cmpFlags_t flags;

  for (genvar k = 0; k < LEVELS; k++) begin : g_stg
    localparam int IN_W  = widthAt(WIDTH, k);
    localparam int OUT_W = widthAt(WIDTH, k + 1);
    logic [IN_W-1:0]  inA;
    logic [IN_W-1:0]  inB;
    logic [OUT_W-1:0] outA;
    logic [OUT_W-1:0] outB;

    if (k == 0) begin : g_first
      assign inA = opA;
      assign inB = opB;
    end else begin : g_next
      assign inA = g_stg[k-1].outA;
      assign inB = g_stg[k-1].outB;
    end

    mag_tree_level #(.IN_W(IN_W)) uLevel (
      .inA  (inA),
      .inB  (inB),
      .outA (outA),
      .outB (outB)
    );
  end

  if (LEVELS == 0) begin : g_flat
    assign finA = opA[0];
    assign finB = opB[0];
  end else begin : g_root
    assign finA = g_stg[LEVELS-1].outA[0];
    assign finB = g_stg[LEVELS-1].outB[0];
  end

  mag_tree_decode uDecode (
    .finA  (finA),
    .finB  (finB),
    .flags (flags)
  );

  assign isGreater = flags.gt;
  assign isEqual   = flags.eq;
  assign isLess    = flags.lt;
endmodule

// File: rtl/mag_tree_cmp_chk.sv
module mag_tree_cmp_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             isGreater,
  input logic             isEqual,
  input logic             isLess
);
  always_comb begin
    p_greater_r1: assert (isGreater == (opA > opB))
      else $error("greater flag disagrees with operands");
    p_equal_r2: assert (isEqual == (opA == opB))
      else $error("equal flag disagrees with operands");
    p_less_r3: assert (isLess == (opA < opB))
      else $error("less flag disagrees with operands");
    p_one_hot_r4: assert ($countones({isGreater, isEqual, isLess}) == 1)
      else $error("flags are not one-hot");
  end
endmodule

bind mag_tree_cmp mag_tree_cmp_chk #(.WIDTH(WIDTH)) uChk (
  .opA       (opA),
  .opB       (opB),
  .isGreater (isGreater),
  .isEqual   (isEqual),
  .isLess    (isLess)
);

// File: tb/tb_mag_tree_cmp.sv
module tb_mag_tree_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  logic [7:0]  a8 = '0,  b8 = '0;
  logic        gt8, eq8, lt8;
  logic [0:0]  a1 = '0,  b1 = '0;
  logic        gt1, eq1, lt1;
  logic [1:0]  a2 = '0,  b2 = '0;
  logic        gt2, eq2, lt2;
  logic [2:0]  a3 = '0,  b3 = '0;
  logic        gt3, eq3, lt3;
  logic [32:0] a33 = '0, b33 = '0;
  logic        gt33, eq33, lt33;

  mag_tree_cmp #(.WIDTH(8))  dut    (.opA(a8),  .opB(b8),  .isGreater(gt8),  .isEqual(eq8),  .isLess(lt8));
  mag_tree_cmp #(.WIDTH(1))  dutW1  (.opA(a1),  .opB(b1),  .isGreater(gt1),  .isEqual(eq1),  .isLess(lt1));
  mag_tree_cmp #(.WIDTH(2))  dutW2  (.opA(a2),  .opB(b2),  .isGreater(gt2),  .isEqual(eq2),  .isLess(lt2));
  mag_tree_cmp #(.WIDTH(3))  dutW3  (.opA(a3),  .opB(b3),  .isGreater(gt3),  .isEqual(eq3),  .isLess(lt3));
  mag_tree_cmp #(.WIDTH(33)) dutW33 (.opA(a33), .opB(b33), .isGreater(gt33), .isEqual(eq33), .isLess(lt33));

  task automatic judge(input string req, input logic [2:0] got, input logic [2:0] exp,
                       input string what);
    vecCount++;
    if (got !== exp) begin
      missCount++;
      $display("FAIL %s %s: got {gt,eq,lt}=%b expected %b", req, what, got, exp);
    end
  endtask

  task automatic try8(input string req, input logic [7:0] x, input logic [7:0] y);
    a8 = x; b8 = y;
    #1;
    judge(req, {gt8, eq8, lt8}, {x > y, x == y, x < y}, $sformatf("w8 %h vs %h", x, y));
  endtask

  task automatic try33(input string req, input logic [32:0] x, input logic [32:0] y);
    a33 = x; b33 = y;
    #1;
    judge(req, {gt33, eq33, lt33}, {x > y, x == y, x < y}, $sformatf("w33 %h vs %h", x, y));
  endtask

  // R5: initial zero operands, then a change with no clock edge in between
  task automatic t_startup_r5();
    #1;
    judge("R2", {gt8, eq8, lt8}, 3'b010, "w8 zero operands at start");
    a8 = 8'h01;
    #1;
    judge("R5", {gt8, eq8, lt8}, 3'b100, "w8 follows input without clock");
    a8 = 8'h00;
    #1;
    judge("R5", {gt8, eq8, lt8}, 3'b010, "w8 no state kept");
  endtask

  // R8: width one, all four pairs
  task automatic t_width1_r8();
    for (int i = 0; i < 4; i++) begin
      a1 = i[1]; b1 = i[0];
      #1;
      judge("R8", {gt1, eq1, lt1}, {i[1] & ~i[0], i[1] == i[0], ~i[1] & i[0]},
            $sformatf("w1 %0d vs %0d", i[1], i[0]));
    end
  endtask

  task automatic t_width2_r1();
    for (int i = 0; i < 16; i++) begin
      a2 = i[3:2]; b2 = i[1:0];
      #1;
      judge("R1", {gt2, eq2, lt2}, {a2 > b2, a2 == b2, a2 < b2}, $sformatf("w2 %0d vs %0d", a2, b2));
    end
  endtask

  // R7: width three needs a padded slot at the first level
  task automatic t_width3_r7();
    for (int i = 0; i < 64; i++) begin
      a3 = i[5:3]; b3 = i[2:0];
      #1;
      judge("R7", {gt3, eq3, lt3}, {a3 > b3, a3 == b3, a3 < b3}, $sformatf("w3 %0d vs %0d", a3, b3));
    end
  endtask

  // R1 R2 R3 R4: exhaustive width eight
  task automatic t_width8_full();
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        try8(i > j ? "R1" : (i == j ? "R2" : "R3"), 8'(i), 8'(j));
      end
    end
  endtask

  // R6 R7: a single deciding bit, lower bits set against the winner
  task automatic t_walk33_r6();
    logic [32:0] upper;
    logic [32:0] mask;
    upper = 33'h0_A5C3_5A3C;
    for (int p = 0; p < 33; p++) begin
      mask = (33'd1 << p) - 33'd1;
      try33("R6", ((upper >> (p + 1)) << (p + 1)) | (33'd1 << p),
                  ((upper >> (p + 1)) << (p + 1)) | mask);
      try33("R6", ((upper >> (p + 1)) << (p + 1)) | mask,
                  ((upper >> (p + 1)) << (p + 1)) | (33'd1 << p));
    end
    try33("R7", 33'h1_0000_0000, 33'h0_FFFF_FFFF);
    try33("R7", 33'h0_FFFF_FFFF, 33'h1_0000_0000);
    try33("R2", 33'h1_FFFF_FFFF, 33'h1_FFFF_FFFF);
  endtask

  task automatic t_random33_r4();
    logic [32:0] lfsr;
    logic [32:0] prev;
    lfsr = 33'h1_2345_6789;
    for (int n = 0; n < 3000; n++) begin
      prev = lfsr;
      for (int s = 0; s < 7; s++) begin
        lfsr = {lfsr[31:0], lfsr[32] ^ lfsr[19]};
      end
      if (n % 5 == 0) try33("R4", prev, prev);
      else            try33("R4", prev, lfsr);
    end
  endtask

  initial begin
    #(CLK_PERIOD*2);
    rstN = 1'b1;
    t_startup_r5();
    t_width1_r8();
    t_width2_r1();
    t_width3_r7();
    t_walk33_r6();
    t_random33_r4();
    t_width8_full();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*WDOG_CYCLES);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule